// File: doc/BRIEF.md
# Hardware Stack Pointer with Limit and Floor Traps

This unit holds the stack pointer of a 16-bit, byte-addressed data space. It works out the memory addresses for pushes and pops and checks each stack access against two bounds: an upper limit that software programs, and a fixed lower floor that keeps the stack out of the special-register region. The stack grows toward higher addresses. The pointer always names the next free word. A push stores at the pointer and then adds two. A pop first subtracts two and then reads at the new address.

On a subroutine call or an exception, the unit saves a 23-bit program counter as a two-word frame over two consecutive cycles. The first word carries the low sixteen PC bits. The second word carries the seven high PC bits and, for an exception only, a status byte in its upper half. When an access breaks a bound, the unit blocks the memory access and leaves the pointer unchanged. It reports the error with a one-cycle pulse and a sticky flag that software clears.

The unit drives a data-memory write port and a read-address strobe. It has no storage of its own apart from the pointer, the limit and the frame state.

Top module: `stack_ptr_unit`

## Requirements
- R1: A synchronous reset sets the pointer to 0x0800 and clears `busy`, `trap_pulse` and `trap_sticky`.
- R2: An accepted push drives `mem_we`=1, `mem_addr` equal to the pointer and `mem_wdata` equal to `push_data` in the request cycle. The pointer reads two higher after the clock edge.
- R3: An accepted pop drives `mem_re`=1 with `mem_addr` equal to the pointer minus two in the request cycle. The pointer reads two lower after the clock edge.
- R4: Bit 0 of a value written through the pointer write port or the limit write port is stored as 0.
- R5: A push made while the pointer equals the limit completes without a trap. A push made while the pointer is above the limit traps: `mem_we` stays 0 and the pointer keeps its value.
- R6: A pop whose decremented address would fall below 0x0800 traps with `mem_re`=0 and the pointer unchanged. A push made while the pointer is below 0x0800 also traps.
- R7: A trapped request raises `trap_pulse` for exactly the one cycle after the request, and sets `trap_sticky`. The sticky flag stays set until `trap_clr` is asserted. If a new trap and a clear arrive together, the flag stays set.
- R8: A call writes `pc_in[15:0]` at the pointer in the request cycle. In the next cycle, with `busy`=1, it writes {9'b0, `pc_in[22:16]`} at the pointer plus two. The pointer then reads four higher.
- R9: An exception saves the same frame, except that its second word is {`status_lo`[7:0], 1'b0, `pc_in[22:16]`}.
- R10: While `busy` is 1, push and pop requests have no effect on memory or the pointer.
- R11: When several requests arrive in one idle cycle, exception wins over call, call over push, and push over pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push one data word |
| push_data | input | 16 | Word to push |
| pop_req | input | 1 | Pop one word |
| call_req | input | 1 | Save a call frame |
| exc_req | input | 1 | Save an exception frame |
| pc_in | input | 23 | Program counter to save |
| status_lo | input | 8 | Status byte for exception frames |
| lim_we | input | 1 | Write the limit register |
| lim_wdata | input | 16 | New limit value |
| sp_we | input | 1 | Write the stack pointer |
| sp_wdata | input | 16 | New pointer value |
| trap_clr | input | 1 | Clear the sticky trap flag |
| mem_we | output | 1 | Data-memory write strobe |
| mem_re | output | 1 | Data-memory read strobe for a pop |
| mem_addr | output | 16 | Data-memory byte address |
| mem_wdata | output | 16 | Data-memory write data |
| sp_out | output | 16 | Current stack pointer |
| busy | output | 1 | Second word of a frame in progress |
| trap_pulse | output | 1 | One-cycle stack-error indication |
| trap_sticky | output | 1 | Latched stack-error flag |

## Verification
The bench pushes and pops from the floor address. It checks that stores land at the pointer and loads at the pointer minus two. It then walks the pointer up to the limit, which separates the allowed push at the limit from the trapping push one word past it. A pop at the floor and a push below the floor exercise the other bound. Call and exception frames are driven with distinct high PC bits and a status byte so that a swapped or unfilled second word shows up. A push issued during the busy cycle, and a push issued together with an exception, expose faults in the ignore rule and the priority rule.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int DW   = 16;
    localparam int PCW  = 23;
    localparam int STW  = 8;
    localparam int PCHW = PCW - DW;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP,
        OP_CALL,
        OP_EXC,
        OP_FRAME2
    } stk_op_e;

    typedef struct packed {
        logic          we;
        logic          re;
        logic [DW-1:0] addr;
        logic [DW-1:0] wdata;
    } mem_req_t;

    function automatic logic [DW-1:0] word_align(input logic [DW-1:0] v);
        return {v[DW-1:1], 1'b0};
    endfunction

    function automatic logic [DW-1:0] frame_hi_word(input logic is_exc,
                                                    input logic [PCHW-1:0] pc_hi,
                                                    input logic [STW-1:0] st);
        logic [DW-1:0] w;
        w = '0;
        w[PCHW-1:0] = pc_hi;
        if (is_exc) w[DW-1:DW-STW] = st;
        return w;
    endfunction
endpackage

// File: rtl/stk_limit_reg.sv
module stk_limit_reg
    import stk_pkg::*;
(
    input  logic          clk,
    input  logic          lim_we,
    input  logic [DW-1:0] lim_wdata,
    output logic [DW-1:0] lim_q
);
    // Deliberately no reset: the limit has no defined value until written.
    always_ff @(posedge clk) begin
        if (lim_we) lim_q <= word_align(lim_wdata);
    end

    always_ff @(posedge clk) begin
        if ($past(lim_we)) assert_lim_aligned_R4: assert (lim_q[0] == 1'b0);
    end
endmodule

// File: rtl/stk_guard.sv
module stk_guard
    import stk_pkg::*;
#(
    parameter logic [DW-1:0] FLOOR = 16'h0800
) (
    input  logic [DW-1:0] sp,
    input  logic [DW-1:0] lim,
    output logic          push_bad,
    output logic          pop_bad
);
    localparam logic [DW-1:0] POP_MIN = FLOOR + 2;

    always_comb begin
        push_bad = (sp > lim) || (sp < FLOOR);
        // The decremented address is compared, so sp < FLOOR+2 is the rule (no wrap).
        pop_bad  = (sp < POP_MIN);
    end
endmodule

// File: rtl/stk_frame_seq.sv
module stk_frame_seq
    import stk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            is_exc,
    input  logic [PCW-1:0]  pc,
    input  logic [STW-1:0]  status,
    output logic            busy,
    output logic [DW-1:0]   hi_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            hi_word <= '0;
        end else begin
            busy <= start && !busy;
            if (start && !busy) hi_word <= frame_hi_word(is_exc, pc[PCW-1:DW], status);
        end
    end

    // R8: a frame occupies exactly one busy cycle.
    assert_busy_single_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stk_pkg::*;
#(
    parameter logic [DW-1:0] FLOOR    = 16'h0800,
    parameter logic [DW-1:0] SP_RESET = 16'h0800
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_req,
    input  logic [DW-1:0]   push_data,
    input  logic            pop_req,
    input  logic            call_req,
    input  logic            exc_req,
    input  logic [PCW-1:0]  pc_in,
    input  logic [STW-1:0]  status_lo,
    input  logic            lim_we,
    input  logic [DW-1:0]   lim_wdata,
    input  logic            sp_we,
    input  logic [DW-1:0]   sp_wdata,
    input  logic            trap_clr,
    output logic            mem_we,
    output logic            mem_re,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW-1:0]   sp_out,
    output logic            busy,
    output logic            trap_pulse,
    output logic            trap_sticky
);
    logic [DW-1:0] sp_q, lim_q, hi_word;
    logic          push_bad, pop_bad, bad, wr_op, frame_start;
    stk_op_e       op;
    mem_req_t      req;

    stk_limit_reg u_lim (
        .clk(clk), .lim_we(lim_we), .lim_wdata(lim_wdata), .lim_q(lim_q)
    );

    stk_guard #(.FLOOR(FLOOR)) u_guard (
        .sp(sp_q), .lim(lim_q), .push_bad(push_bad), .pop_bad(pop_bad)
    );

    stk_frame_seq u_frame (
        .clk(clk), .rst(rst), .start(frame_start), .is_exc(op == OP_EXC),
        .pc(pc_in), .status(status_lo), .busy(busy), .hi_word(hi_word)
    );

    // Request arbitration: frame tail, then exception > call > push > pop.
    always_comb begin
        if (busy)          op = OP_FRAME2;
        else if (exc_req)  op = OP_EXC;
        else if (call_req) op = OP_CALL;
        else if (push_req) op = OP_PUSH;
        else if (pop_req)  op = OP_POP;
        else               op = OP_NONE;
    end

    always_comb begin
        wr_op = (op == OP_PUSH) || (op == OP_CALL) || (op == OP_EXC) || (op == OP_FRAME2);
        bad   = wr_op ? push_bad : ((op == OP_POP) ? pop_bad : 1'b0);
        frame_start = ((op == OP_CALL) || (op == OP_EXC)) && !bad;

        req.we    = wr_op && !bad;
        req.re    = (op == OP_POP) && !bad;
        req.addr  = (op == OP_POP) ? sp_q - 16'd2 : sp_q;
        case (op)
            OP_PUSH:        req.wdata = push_data;
            OP_CALL, OP_EXC: req.wdata = pc_in[DW-1:0];
            OP_FRAME2:      req.wdata = hi_word;
            default:        req.wdata = '0;
        endcase
    end

    assign mem_we    = req.we;
    assign mem_re    = req.re;
    assign mem_addr  = req.addr;
    assign mem_wdata = req.wdata;
    assign sp_out    = sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q        <= SP_RESET;
            trap_pulse  <= 1'b0;
            trap_sticky <= 1'b0;
        end else begin
            if (sp_we)        sp_q <= word_align(sp_wdata);
            else if (req.we)  sp_q <= sp_q + 16'd2;
            else if (req.re)  sp_q <= sp_q - 16'd2;
            trap_pulse <= bad;
            if (bad)           trap_sticky <= 1'b1;
            else if (trap_clr) trap_sticky <= 1'b0;
        end
    end

    // R5: stores never land above the programmed limit.
    assert_write_in_limit_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr <= lim_q));
    // R6: no access below the floor.
    assert_floor_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> (mem_addr >= FLOOR));
    // R2: an accepted store advances the pointer by one word.
    assert_push_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !sp_we) |=> (sp_q == $past(sp_q) + 16'd2));
    // R7: a pulse is always accompanied by the sticky flag.
    assert_sticky_follows_R7: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> trap_sticky);
    // R4: the pointer stays word aligned.
    assert_sp_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        sp_q[0] == 1'b0);
endmodule

// File: tb/stack_ptr_unit_bench.sv
module stack_ptr_unit_bench;
    import stk_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic push_req = 0, pop_req = 0, call_req = 0, exc_req = 0;
    logic lim_we = 0, sp_we = 0, trap_clr = 0;
    logic [15:0] push_data = '0, lim_wdata = '0, sp_wdata = '0;
    logic [22:0] pc_in = '0;
    logic [7:0]  status_lo = '0;
    logic        mem_we, mem_re, busy, trap_pulse, trap_sticky;
    logic [15:0] mem_addr, mem_wdata, sp_out;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    stack_ptr_unit u_stack_ptr_unit (
        .clk(clk), .rst(rst), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .call_req(call_req), .exc_req(exc_req), .pc_in(pc_in),
        .status_lo(status_lo), .lim_we(lim_we), .lim_wdata(lim_wdata),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .trap_clr(trap_clr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .sp_out(sp_out), .busy(busy), .trap_pulse(trap_pulse), .trap_sticky(trap_sticky)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Go to the next edge, then sample 1 ns after it.
    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Drive inputs at a falling edge.
    task automatic at_neg();
        @(negedge clk); #1;
    endtask

    task automatic idle();
        push_req = 0; pop_req = 0; call_req = 0; exc_req = 0;
        lim_we = 0; sp_we = 0; trap_clr = 0;
    endtask

    task automatic set_sp(input logic [15:0] v);
        at_neg(); sp_we = 1; sp_wdata = v; tick(); idle();
    endtask

    task automatic set_lim(input logic [15:0] v);
        at_neg(); lim_we = 1; lim_wdata = v; tick(); idle();
    endtask

    task automatic t_reset();
        chk("R1 sp", sp_out, 16'h0800);
        chk("R1 busy", busy, 0);
        chk("R1 pulse", trap_pulse, 0);
        chk("R1 sticky", trap_sticky, 0);
    endtask

    task automatic t_push_pop();
        at_neg(); push_req = 1; push_data = 16'h1111; #1;
        chk("R2 we", mem_we, 1); chk("R2 addr", mem_addr, 16'h0800);
        chk("R2 data", mem_wdata, 16'h1111);
        tick(); idle(); chk("R2 sp", sp_out, 16'h0802);
        at_neg(); pop_req = 1; #1;
        chk("R3 re", mem_re, 1); chk("R3 addr", mem_addr, 16'h0800);
        tick(); idle(); chk("R3 sp", sp_out, 16'h0800);
    endtask

    task automatic t_floor();
        at_neg(); pop_req = 1; #1;
        chk("R6 pop re", mem_re, 0);
        tick(); idle();
        chk("R6 pop sp", sp_out, 16'h0800);
        chk("R7 pulse", trap_pulse, 1); chk("R7 sticky", trap_sticky, 1);
        tick();
        chk("R7 pulse one cycle", trap_pulse, 0); chk("R7 sticky held", trap_sticky, 1);
        at_neg(); trap_clr = 1; tick(); idle();
        chk("R7 cleared", trap_sticky, 0);
        set_sp(16'h0700);
        at_neg(); push_req = 1; push_data = 16'h2222; #1;
        chk("R6 low push we", mem_we, 0);
        trap_clr = 1; tick(); idle();
        chk("R7 set wins", trap_sticky, 1);
        chk("R6 low push sp", sp_out, 16'h0700);
        at_neg(); trap_clr = 1; tick(); idle();
    endtask

    task automatic t_limit();
        set_sp(16'h0A01);
        chk("R4 sp bit0", sp_out, 16'h0A00);
        set_lim(16'h0A03);
        at_neg(); push_req = 1; push_data = 16'h3333; tick(); idle();
        at_neg(); push_req = 1; push_data = 16'h4444; #1;
        chk("R5 push at limit", mem_we, 1); chk("R4 limit aligned", mem_addr, 16'h0A02);
        tick(); idle();
        chk("R5 no trap at limit", trap_pulse, 0);
        at_neg(); push_req = 1; push_data = 16'h5555; #1;
        chk("R5 push past limit", mem_we, 0);
        tick(); idle();
        chk("R5 trap", trap_pulse, 1); chk("R5 sp kept", sp_out, 16'h0A04);
        at_neg(); trap_clr = 1; tick(); idle();
    endtask

    task automatic t_call();
        set_lim(16'h0F00);
        set_sp(16'h0900);
        at_neg(); call_req = 1; pc_in = 23'h5A_1234; #1;
        chk("R8 w1 we", mem_we, 1); chk("R8 w1 addr", mem_addr, 16'h0900);
        chk("R8 w1 data", mem_wdata, 16'h1234);
        tick(); idle();
        chk("R8 busy", busy, 1);
        at_neg(); push_req = 1; push_data = 16'h6666; pop_req = 0; #1;
        chk("R8 w2 addr", mem_addr, 16'h0902);
        chk("R10 w2 data not push", mem_wdata, 16'h005A);
        tick(); idle();
        chk("R8 busy done", busy, 0);
        chk("R10 sp", sp_out, 16'h0904);
    endtask

    task automatic t_exc();
        at_neg(); exc_req = 1; push_req = 1; push_data = 16'h7777;
        pc_in = 23'h7F_0001; status_lo = 8'hC3; #1;
        chk("R11 exc wins", mem_wdata, 16'h0001);
        chk("R11 addr", mem_addr, 16'h0904);
        tick(); idle(); #1;
        chk("R9 w2 data", mem_wdata, 16'hC37F);
        chk("R9 w2 addr", mem_addr, 16'h0906);
        tick();
        chk("R9 sp", sp_out, 16'h0908);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        set_lim(16'h0A00);
        t_push_pop();
        t_floor();
        t_limit();
        t_call();
        t_exc();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule